// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit core and a word-wide data memory. On a store it turns a byte address, an access size and the store data into three things: a word address, one write enable per byte lane, and the data moved onto the lanes that the access covers. On a load it passes the word address to the memory. In the next cycle it takes the returned word, picks out the addressed byte, halfword or word, and zero- or sign-extends it to 32 bits.

A run-time input selects how byte addresses map onto lanes. In little-endian numbering, byte offset 0 sits in bits 7:0. In big-endian numbering, byte offset 0 sits in bits 31:24. An access that does not sit on a boundary of its own size is rejected in the same cycle. A rejected access raises a fault flag and reaches no memory.

Top module: `lsu_align`

## Requirements
- R1: For every request, `mem_addr_o` equals `addr_i[31:2]` (byte address with the low two bits dropped).
- R2: `fault_o` is high in the request cycle when the request is misaligned. Size code 2'b01 (halfword) faults when `addr_i[0]`=1. Size code 2'b10 (word) faults when `addr_i[1:0]`!=0. Size code 2'b11 always faults. Size code 2'b00 (byte) never faults.
- R3: A faulted request drives `mem_req_o` low and `mem_we_o` to 4'b0000, and it produces no `rvalid_o` in the next cycle.
- R4: A byte store enables exactly one lane and places `wdata_i[7:0]` there. The lane is offset `addr_i[1:0]` in little-endian mode (`big_endian_i`=0) and 3 minus that offset in big-endian mode.
- R5: A halfword store enables exactly two lanes. Little-endian puts `wdata_i[7:0]` on lane offset and `wdata_i[15:8]` on lane offset+1. Big-endian puts `wdata_i[15:8]` on lane 3-offset and `wdata_i[7:0]` on lane 2-offset.
- R6: An aligned word store enables all four lanes and drives `wdata_i` unchanged, whatever the byte order.
- R7: A byte load returns the byte from the lane that R4 selects for the same address and mode.
- R8: A halfword load returns the two bytes from the lanes that R5 selects, with the byte at the lower address as the least significant byte in little-endian mode and as the most significant byte in big-endian mode. A word load returns `mem_rdata_i` unchanged.
- R9: With `signed_i`=1, byte and halfword loads copy the field's top bit into all upper result bits. With `signed_i`=0, the upper bits are zero.
- R10: `rvalid_o` is high exactly in the cycle after an accepted load (`req_i`=1, `we_i`=0, no fault). In that cycle `rdata_o` is formed from `mem_rdata_i`.
- R11: During and right after reset, `rvalid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 32 | Byte address |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 invalid |
| signed_i | input | 1 | Sign-extend sub-word loads |
| big_endian_i | input | 1 | Lane numbering: 0 little, 1 big |
| wdata_i | input | 32 | Store data, right-aligned |
| mem_req_o | output | 1 | Memory access strobe |
| mem_addr_o | output | 30 | Word address |
| mem_we_o | output | 4 | Per-lane write enables |
| mem_wdata_o | output | 32 | Lane-aligned store data |
| mem_rdata_i | input | 32 | Read word, one cycle after request |
| fault_o | output | 1 | Misalignment fault, same cycle |
| rdata_o | output | 32 | Extended load result |
| rvalid_o | output | 1 | Load result valid |

## Verification
The bench drives every offset under both byte orders. It checks each lane against a byte-by-byte memory model. A mirrored lane map would show up as the wrong byte being written or returned in one of the two modes. Sign extension is tested with the field's top bit both set and clear, so sign and zero fill are each seen. Misaligned halfword and word requests and the invalid size code are driven both as stores and as loads. A design that let one of them through would show a stray write enable, a memory strobe or a late valid pulse. The valid pulse is checked in the cycle after each load and after each non-load, so a pulse that is missing, late or extra is caught.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned OFF_W  = $clog2(LANES);
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
  import lsu_align_pkg::*;
(
  input  acc_size_e              size_i,
  input  logic [OFF_W-1:0]       off_i,
  output logic                   misal_o
);
  always_comb begin
    unique case (size_i)
      SZ_BYTE: misal_o = 1'b0;
      SZ_HALF: misal_o = off_i[0];
      SZ_WORD: misal_o = |off_i;
      default: misal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_align_pkg::*;
(
  input  acc_size_e              size_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic                   big_endian_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [LANES-1:0]       lane_en_o,
  output logic [DATA_W-1:0]      lane_data_o
);
  logic [OFF_W-1:0] byte_lane;
  logic             half_hi;

  // big-endian mirrors the lane index
  assign byte_lane = off_i ^ {OFF_W{big_endian_i}};
  assign half_hi   = off_i[1] ^ big_endian_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(g);
    always_comb begin
      unique case (size_i)
        SZ_BYTE: begin
          lane_en_o[g]         = (LANE_IDX == byte_lane);
          lane_data_o[8*g +: 8] = wdata_i[7:0];
        end
        SZ_HALF: begin
          lane_en_o[g]         = (LANE_IDX[1] == half_hi);
          lane_data_o[8*g +: 8] = wdata_i[8*(g%2) +: 8];
        end
        SZ_WORD: begin
          lane_en_o[g]         = 1'b1;
          lane_data_o[8*g +: 8] = wdata_i[8*g +: 8];
        end
        default: begin
          lane_en_o[g]         = 1'b0;
          lane_data_o[8*g +: 8] = wdata_i[8*g +: 8];
        end
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_unit.sv
module lsu_load_unit
  import lsu_align_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   take_i,
  input  acc_size_e              size_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic                   signed_i,
  input  logic                   big_endian_i,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rvalid_o
);
  acc_size_e        size_q;
  logic [OFF_W-1:0] off_q;
  logic             sgn_q;
  logic             be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      size_q   <= SZ_WORD;
      off_q    <= '0;
      sgn_q    <= 1'b0;
      be_q     <= 1'b0;
    end else begin
      rvalid_o <= take_i;
      if (take_i) begin
        size_q <= size_i;
        off_q  <= off_i;
        sgn_q  <= signed_i;
        be_q   <= big_endian_i;
      end
    end
  end

  logic [OFF_W-1:0] byte_lane;
  logic             half_hi;
  logic [7:0]       byte_f;
  logic [15:0]      half_f;

  assign byte_lane = off_q ^ {OFF_W{be_q}};
  assign half_hi   = off_q[1] ^ be_q;
  assign byte_f    = mem_rdata_i[8*byte_lane +: 8];
  assign half_f    = half_hi ? mem_rdata_i[31:16] : mem_rdata_i[15:0];

  always_comb begin
    unique case (size_q)
      SZ_BYTE: rdata_o = {{(DATA_W-8){sgn_q & byte_f[7]}}, byte_f};
      SZ_HALF: rdata_o = {{(DATA_W-16){sgn_q & half_f[15]}}, half_f};
      default: rdata_o = mem_rdata_i;
    endcase
  end

  assert_unsigned_half_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && size_q == SZ_HALF && !sgn_q) |-> (rdata_o[31:16] == 16'h0));
  assert_unsigned_byte_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && size_q == SZ_BYTE && !sgn_q) |-> (rdata_o[31:8] == 24'h0));
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [1:0]             size_i,
  input  logic                   signed_i,
  input  logic                   big_endian_i,
  input  logic [31:0]            wdata_i,
  output logic                   mem_req_o,
  output logic [ADDR_W-3:0]      mem_addr_o,
  output logic [3:0]             mem_we_o,
  output logic [31:0]            mem_wdata_o,
  input  logic [31:0]            mem_rdata_i,
  output logic                   fault_o,
  output logic [31:0]            rdata_o,
  output logic                   rvalid_o
);
  acc_size_e        size_e;
  logic [OFF_W-1:0] off;
  logic             misal;
  logic [LANES-1:0] lane_en;
  logic             accept;

  assign size_e = acc_size_e'(size_i);
  assign off    = addr_i[OFF_W-1:0];

  lsu_align_check u_check (
    .size_i (size_e),
    .off_i  (off),
    .misal_o(misal)
  );

  lsu_store_lane u_store (
    .size_i      (size_e),
    .off_i       (off),
    .big_endian_i(big_endian_i),
    .wdata_i     (wdata_i),
    .lane_en_o   (lane_en),
    .lane_data_o (mem_wdata_o)
  );

  assign fault_o    = req_i & misal;
  assign accept     = req_i & ~misal;
  assign mem_req_o  = accept;
  assign mem_addr_o = addr_i[ADDR_W-1:OFF_W];
  assign mem_we_o   = (accept & we_i) ? lane_en : '0;

  lsu_load_unit u_load (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (accept & ~we_i),
    .size_i      (size_e),
    .off_i       (off),
    .signed_i    (signed_i),
    .big_endian_i(big_endian_i),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

  assert_fault_blocks_mem_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (mem_we_o == 4'b0000 && !mem_req_o));
  assert_word_misal_faults_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'b10 && addr_i[1:0] != 2'b00) |-> fault_o);
  assert_byte_one_lane_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == 2'b00) |-> ($countones(mem_we_o) == 1));
  assert_half_two_lanes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && size_i == 2'b01 && !fault_o) |-> ($countones(mem_we_o) == 2));
  assert_load_valid_next_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !fault_o) |=> rvalid_o);
  assert_no_stray_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i && !fault_o) |=> !rvalid_o);
endmodule

// File: tb/lsu_align_bench.sv
module lsu_align_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [1:0]  size_i = '0;
  logic        signed_i = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        mem_req_o;
  logic [29:0] mem_addr_o;
  logic [3:0]  mem_we_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        fault_o;
  logic [31:0] rdata_o;
  logic        rvalid_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  lsu_align u_lsu_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .signed_i(signed_i), .big_endian_i(big_endian_i), .wdata_i(wdata_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .fault_o(fault_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic bit misaligned(logic [1:0] sz, logic [1:0] off);
    if (sz == 2'b11) return 1'b1;
    return (int'(off) % nbytes(sz)) != 0;
  endfunction

  function automatic int lane_of(int a, bit be);
    return be ? 3 - a : a;
  endfunction

  // byte k of the value goes to address off+k (LE) or off+n-1-k (BE)
  task automatic model_store(logic [1:0] sz, logic [1:0] off, bit be, logic [31:0] d,
                             output logic [3:0] en, output logic [31:0] dat);
    int n = nbytes(sz);
    en = '0; dat = '0;
    for (int k = 0; k < n; k++) begin
      int a = int'(off) + k;
      int src = be ? (n - 1 - k) : k;
      en[lane_of(a, be)] = 1'b1;
      dat[8*lane_of(a, be) +: 8] = d[8*src +: 8];
    end
  endtask

  function automatic logic [31:0] model_load(logic [1:0] sz, logic [1:0] off, bit be,
                                             bit sg, logic [31:0] w);
    int n = nbytes(sz);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) begin
      int a = int'(off) + k;
      int dst = be ? (n - 1 - k) : k;
      v[8*dst +: 8] = w[8*lane_of(a, be) +: 8];
    end
    if (sg && n < 4 && v[8*n-1]) for (int b = 8*n; b < 32; b++) v[b] = 1'b1;
    return v;
  endfunction

  task automatic do_store(logic [31:0] a, logic [1:0] sz, bit be, logic [31:0] d);
    logic [3:0] een; logic [31:0] edat; bit mis;
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; size_i = sz; big_endian_i = be; wdata_i = d;
    #1;
    mis = misaligned(sz, a[1:0]);
    model_store(sz, a[1:0], be, d, een, edat);
    chk("R1 mem_addr", {2'b0, mem_addr_o}, {2'b0, a[31:2]});
    chk("R2 fault", {31'b0, fault_o}, {31'b0, mis});
    if (mis) begin
      chk("R3 store we", {28'b0, mem_we_o}, 32'h0);
      chk("R3 store req", {31'b0, mem_req_o}, 32'h0);
    end else begin
      chk(sz == 2'b00 ? "R4 we" : sz == 2'b01 ? "R5 we" : "R6 we", {28'b0, mem_we_o}, {28'b0, een});
      for (int l = 0; l < 4; l++)
        if (een[l]) chk(sz == 2'b00 ? "R4 lane data" : sz == 2'b01 ? "R5 lane data" : "R6 lane data",
                        {24'b0, mem_wdata_o[8*l +: 8]}, {24'b0, edat[8*l +: 8]});
    end
    @(negedge clk_i);
    req_i = 0;
    #1;
    chk("R10 no valid after store", {31'b0, rvalid_o}, 32'h0);
  endtask

  task automatic do_load(logic [31:0] a, logic [1:0] sz, bit be, bit sg, logic [31:0] w);
    bit mis;
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a; size_i = sz; big_endian_i = be; signed_i = sg;
    #1;
    mis = misaligned(sz, a[1:0]);
    chk("R1 load addr", {2'b0, mem_addr_o}, {2'b0, a[31:2]});
    chk("R2 load fault", {31'b0, fault_o}, {31'b0, mis});
    chk("R3 load req", {31'b0, mem_req_o}, {31'b0, !mis});
    @(negedge clk_i);
    req_i = 0; mem_rdata_i = w;
    big_endian_i = ~be; signed_i = ~sg; addr_i = ~a; size_i = ~sz;
    #1;
    if (mis) chk("R3 no valid after fault", {31'b0, rvalid_o}, 32'h0);
    else begin
      chk("R10 rvalid", {31'b0, rvalid_o}, 32'h1);
      chk(sz == 2'b00 ? "R7 R9 byte load" : sz == 2'b01 ? "R8 R9 half load" : "R8 word load",
          rdata_o, model_load(sz, a[1:0], be, sg, w));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    #3;
    chk("R11 rvalid in reset", {31'b0, rvalid_o}, 32'h0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    #1;
    chk("R11 rvalid after reset", {31'b0, rvalid_o}, 32'h0);

    // directed: every offset, both orders
    for (int be = 0; be < 2; be++)
      for (int o = 0; o < 4; o++) begin
        do_store(32'h1000_0000 + 32'(o), 2'b00, bit'(be), 32'hCAFE_BEA5);
        do_store(32'h1000_0000 + 32'(o), 2'b01, bit'(be), 32'h0000_A1B2);
        do_store(32'h1000_0000 + 32'(o), 2'b10, bit'(be), 32'h1122_3344);
        do_store(32'h1000_0000 + 32'(o), 2'b11, bit'(be), 32'h5566_7788);
        do_load(32'h2000_0000 + 32'(o), 2'b00, bit'(be), 1'b1, 32'h80F1_7F92);
        do_load(32'h2000_0000 + 32'(o), 2'b00, bit'(be), 1'b0, 32'h80F1_7F92);
        do_load(32'h2000_0000 + 32'(o), 2'b01, bit'(be), 1'b1, 32'h8001_7FFE);
        do_load(32'h2000_0000 + 32'(o), 2'b01, bit'(be), 1'b0, 32'h8001_7FFE);
        do_load(32'h2000_0000 + 32'(o), 2'b10, bit'(be), 1'b1, 32'hDEAD_BEEF);
        do_load(32'h2000_0000 + 32'(o), 2'b11, bit'(be), 1'b0, 32'hDEAD_BEEF);
      end

    // back-to-back loads
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = 32'h40; size_i = 2'b00; big_endian_i = 0; signed_i = 1;
    @(negedge clk_i);
    mem_rdata_i = 32'h0000_0085; addr_i = 32'h46; size_i = 2'b01; big_endian_i = 1; signed_i = 0;
    #1;
    chk("R10 b2b first", rdata_o, 32'hFFFF_FF85);
    @(negedge clk_i);
    req_i = 0; mem_rdata_i = 32'h1234_9ABC;
    #1;
    chk("R10 b2b second", rdata_o, 32'h0000_9ABC);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom;
      logic [1:0]  sz = 2'($urandom % 4);
      bit          be = bit'($urandom % 2);
      if (($urandom % 3) != 0) a[1:0] = (sz == 2'b00) ? a[1:0] : (sz == 2'b01) ? {a[1], 1'b0} : 2'b00;
      if ($urandom % 2) do_store(a, sz, be, $urandom);
      else do_load(a, sz, be, bit'($urandom % 2), $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule